// File: doc/BRIEF.md
# Display Control Shadow-Register Updater

This block keeps the control state of a raster display controller in two layers. The CPU writes into a staging layer: display reset, display enable, a two-bit sync-source mode, and a display-size value. The active layer drives the display pipeline. It takes a copy of every staged value at one internal update point per frame, on the first clock of vertical blanking. Because of this, software can reprogram the display at any time without tearing a frame. It can also switch the display on or off cleanly.

A sticky blanking-update flag confirms each update. Software clears the flag by a write, then polls until it reads 1. At that point the values it staged earlier are known to be in force. Readback shows the staged values and the active values at separate addresses. In switching mode (sync mode 01) updates keep running, so the frame strobe that memory refresh uses keeps running too, while the display output is held off. In external sync mode (10) the update point comes from the external blanking input instead of the internal one.

Top module: `disp_ctl_shadow`

## Requirements
- R1: After reset every staged and active value is 0. The display is off, sync mode is 00, the blanking-update flag is 0 and `restart_o` is 0.
- R2: A CPU write to address 0 (control: bit 0 display reset, bit 1 display enable, bits 3:2 sync mode) or address 1 (size, low SIZE_W bits) changes only the staged value. Reading address 0 or 1 returns the last value written. The active outputs stay unchanged until an update.
- R3: `upd_o` is high for exactly one cycle, on the first clock at which the selected blanking input is high after being low. It is not high again while that input stays high.
- R4: On an update cycle, all staged values are copied into the active registers together at that clock edge.
- R5: A CPU write in the same cycle as an update lands in the staging register. The active register takes the staged value from before that write.
- R6: The display is on only when the active display reset is 0 and the active display enable is 1. If display reset is 1, the display is off whatever the value of display enable. `disp_rst_o` reflects the active reset bit.
- R7: `restart_o` pulses for one cycle after an update that turns the display from off to on. It marks a restart of scanout from the start address.
- R8: The flag is cleared by any write to address 2 and set by an update. If both happen in the same cycle, the set wins. Reading address 2 returns the flag in bit 0.
- R9: With active sync mode 10, only a rising edge of `ext_vblank_i` makes an update. With modes 00, 01 and 11, only a rising edge of `vblank_i` does.
- R10: With active sync mode 01 the display is held off, whatever the reset and enable bits say, but updates still take place.
- R11: Reading address 3 returns the active control value and address 4 the active size. Any other unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | CPU write strobe |
| wr_addr_i | input | 3 | CPU write address |
| wr_data_i | input | DATA_W | CPU write data |
| rd_addr_i | input | 3 | CPU read address |
| rd_data_o | output | DATA_W | CPU read data (combinational) |
| vblank_i | input | 1 | Internal vertical blanking level |
| ext_vblank_i | input | 1 | External vertical blanking level |
| upd_o | output | 1 | Internal update strobe |
| vbk_o | output | 1 | Blanking-update flag |
| disp_on_o | output | 1 | Active display-on state |
| disp_rst_o | output | 1 | Active display reset bit |
| restart_o | output | 1 | Scanout restart pulse |
| sync_mode_o | output | 2 | Active sync mode |
| size_o | output | SIZE_W | Active display-size value |

## Verification
On every cycle the assertions check several rules:
- the active layer holds outside update cycles and equals the previous staged values after an update;
- the display is held off under reset or switching mode;
- each blanking edge detector fires only once per level;
- the flag is set by an update and is cleared by a lone clear write.

Some behaviour needs chosen stimulus, so only the bench scenarios show it. This covers the write-versus-update collision, the set-over-clear priority of the flag, the change of update source in external sync mode, the restart pulse, and the readback map.

// File: rtl/disp_ctl_pkg.sv
package disp_ctl_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SIZE = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_ACTL = 3'd3;
  localparam logic [ADDR_W-1:0] A_ASZ  = 3'd4;

  typedef enum logic [1:0] {
    MODE_INT = 2'b00,
    MODE_SW  = 2'b01,
    MODE_EXT = 2'b10,
    MODE_RSV = 2'b11
  } sync_mode_e;

  // bit order matches the control register layout
  typedef struct packed {
    sync_mode_e mode;
    logic       den;
    logic       dres;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic logic ctl_on(ctl_t c);
    return !c.dres && c.den && (c.mode != MODE_SW);
  endfunction
endpackage

// File: rtl/disp_ctl_stage.sv
module disp_ctl_stage
  import disp_ctl_pkg::*;
#(
  parameter int SIZE_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output ctl_t              stg_ctl_o,
  output logic [SIZE_W-1:0] stg_size_o,
  output logic              vbk_clr_o
);
  logic wr_ctl, wr_size;

  assign wr_ctl    = wr_en_i && (wr_addr_i == A_CTL);
  assign wr_size   = wr_en_i && (wr_addr_i == A_SIZE);
  assign vbk_clr_o = wr_en_i && (wr_addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_ctl_o  <= '0;
      stg_size_o <= '0;
    end else begin
      if (wr_ctl)  stg_ctl_o  <= ctl_t'(wr_data_i[CTL_W-1:0]);
      if (wr_size) stg_size_o <= wr_data_i[SIZE_W-1:0];
    end
  end

  assert_stage_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(stg_ctl_o) && $stable(stg_size_o));
endmodule

// File: rtl/disp_ctl_sync.sv
module disp_ctl_sync
  import disp_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vblank_i,
  input  logic       ext_vblank_i,
  input  sync_mode_e act_mode_i,
  input  logic       vbk_clr_i,
  output logic       upd_o,
  output logic       vbk_o
);
  logic int_q, ext_q, int_rise, ext_rise;

  assign int_rise = vblank_i && !int_q;
  assign ext_rise = ext_vblank_i && !ext_q;
  assign upd_o    = (act_mode_i == MODE_EXT) ? ext_rise : int_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= 1'b0;
      ext_q <= 1'b0;
      vbk_o <= 1'b0;
    end else begin
      int_q <= vblank_i;
      ext_q <= ext_vblank_i;
      if (upd_o)          vbk_o <= 1'b1;
      else if (vbk_clr_i) vbk_o <= 1'b0;
    end
  end

  assert_int_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rise |=> !int_rise);
  assert_ext_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rise |=> !ext_rise);
  assert_vbk_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> vbk_o);
  assert_vbk_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vbk_clr_i && !upd_o |=> !vbk_o);
endmodule

// File: rtl/disp_ctl_active.sv
module disp_ctl_active
  import disp_ctl_pkg::*;
#(
  parameter int SIZE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  ctl_t              stg_ctl_i,
  input  logic [SIZE_W-1:0] stg_size_i,
  output ctl_t              act_ctl_o,
  output logic [SIZE_W-1:0] act_size_o,
  output logic              disp_on_o,
  output logic              restart_o
);
  assign disp_on_o = ctl_on(act_ctl_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_ctl_o  <= '0;
      act_size_o <= '0;
      restart_o  <= 1'b0;
    end else begin
      restart_o <= upd_i && ctl_on(stg_ctl_i) && !disp_on_o;
      if (upd_i) begin
        act_ctl_o  <= stg_ctl_i;
        act_size_o <= stg_size_i;
      end
    end
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(act_ctl_o) && $stable(act_size_o));
  assert_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (act_ctl_o == $past(stg_ctl_i)) && (act_size_o == $past(stg_size_i)));
  assert_dres_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_ctl_o.dres |-> !disp_on_o);
  assert_sw_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_ctl_o.mode == MODE_SW) |-> !disp_on_o);
  assert_restart_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> disp_on_o && !$past(disp_on_o));
endmodule

// File: rtl/disp_ctl_shadow.sv
module disp_ctl_shadow
  import disp_ctl_pkg::*;
#(
  parameter int SIZE_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              vblank_i,
  input  logic              ext_vblank_i,
  output logic              upd_o,
  output logic              vbk_o,
  output logic              disp_on_o,
  output logic              disp_rst_o,
  output logic              restart_o,
  output logic [1:0]        sync_mode_o,
  output logic [SIZE_W-1:0] size_o
);
  ctl_t              stg_ctl, act_ctl;
  logic [SIZE_W-1:0] stg_size;
  logic              vbk_clr;

  disp_ctl_stage #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_stage (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .stg_ctl_o(stg_ctl), .stg_size_o(stg_size), .vbk_clr_o(vbk_clr)
  );

  disp_ctl_sync u_sync (
    .clk_i, .rst_ni, .vblank_i, .ext_vblank_i,
    .act_mode_i(act_ctl.mode), .vbk_clr_i(vbk_clr),
    .upd_o, .vbk_o
  );

  disp_ctl_active #(.SIZE_W(SIZE_W)) u_active (
    .clk_i, .rst_ni, .upd_i(upd_o),
    .stg_ctl_i(stg_ctl), .stg_size_i(stg_size),
    .act_ctl_o(act_ctl), .act_size_o(size_o),
    .disp_on_o, .restart_o
  );

  assign disp_rst_o  = act_ctl.dres;
  assign sync_mode_o = act_ctl.mode;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTL:   rd_data_o = DATA_W'(stg_ctl);
      A_SIZE:  rd_data_o = DATA_W'(stg_size);
      A_STAT:  rd_data_o = DATA_W'(vbk_o);
      A_ACTL:  rd_data_o = DATA_W'(act_ctl);
      A_ASZ:   rd_data_o = DATA_W'(size_o);
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: tb/tb_disp_ctl_shadow.sv
`timescale 1ns/1ps
module tb_disp_ctl_shadow;
  localparam int SIZE_W = 12;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic vblank_i = 1'b0, ext_vblank_i = 1'b0;
  logic upd_o, vbk_o, disp_on_o, disp_rst_o, restart_o;
  logic [1:0] sync_mode_o;
  logic [SIZE_W-1:0] size_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  disp_ctl_shadow #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .vblank_i, .ext_vblank_i,
    .upd_o, .vbk_o, .disp_on_o, .disp_rst_o, .restart_o,
    .sync_mode_o, .size_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DATA_W-1:0] d);
    rd_addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic pulse(input bit ext);
    @(negedge clk);
    if (ext) ext_vblank_i = 1'b1; else vblank_i = 1'b1;
    @(negedge clk);
    vblank_i = 1'b0; ext_vblank_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DATA_W-1:0] d;
    chk("R1 disp_on", disp_on_o, 0);
    chk("R1 mode", sync_mode_o, 0);
    chk("R1 vbk", vbk_o, 0);
    chk("R1 restart", restart_o, 0);
    chk("R1 size", size_o, 0);
    rd(3'd0, d); chk("R1 staged ctl", d, 0);
    rd(3'd3, d); chk("R1 active ctl", d, 0);
  endtask

  task automatic t_stage_hold;
    logic [DATA_W-1:0] d;
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'h0123);
    repeat (3) @(negedge clk);
    rd(3'd0, d); chk("R2 staged ctl", d, 16'h0002);
    rd(3'd1, d); chk("R2 staged size", d, 16'h0123);
    chk("R2 active size held", size_o, 0);
    chk("R2 display held off", disp_on_o, 0);
  endtask

  task automatic t_update;
    logic [DATA_W-1:0] d;
    @(negedge clk);
    vblank_i = 1'b1;
    #1 chk("R3 strobe on first blank clock", upd_o, 1);
    @(negedge clk);
    chk("R3 no strobe while blank held", upd_o, 0);
    chk("R4 size applied", size_o, 12'h123);
    chk("R6 display on", disp_on_o, 1);
    chk("R7 restart pulse", restart_o, 1);
    chk("R8 flag set", vbk_o, 1);
    @(negedge clk);
    chk("R7 restart one cycle", restart_o, 0);
    chk("R3 still no strobe", upd_o, 0);
    vblank_i = 1'b0;
    rd(3'd3, d); chk("R11 active ctl", d, 16'h0002);
    rd(3'd4, d); chk("R11 active size", d, 16'h0123);
  endtask

  task automatic t_collision;
    logic [DATA_W-1:0] d;
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 16'h0003; vblank_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; vblank_i = 1'b0;
    rd(3'd3, d); chk("R5 active got old staged", d, 16'h0002);
    rd(3'd0, d); chk("R5 staged got write", d, 16'h0003);
    pulse(0);
    chk("R6 reset forces off with enable", disp_on_o, 0);
    chk("R6 disp_rst", disp_rst_o, 1);
    wr(3'd0, 16'h0000);
    pulse(0);
    chk("R6 off with reset and enable clear", disp_on_o, 0);
    chk("R6 disp_rst clear", disp_rst_o, 0);
    wr(3'd0, 16'h0002);
    pulse(0);
    chk("R6 on again", disp_on_o, 1);
  endtask

  task automatic t_flag;
    logic [DATA_W-1:0] d;
    wr(3'd2, 16'h0000);
    chk("R8 flag cleared", vbk_o, 0);
    repeat (2) @(negedge clk);
    rd(3'd2, d); chk("R8 flag stays clear", d, 0);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 3'd2; vblank_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; vblank_i = 1'b0;
    chk("R8 set beats clear", vbk_o, 1);
  endtask

  task automatic t_ext;
    wr(3'd0, 16'h000A);
    pulse(0);
    chk("R9 mode ext applied", sync_mode_o, 2'b10);
    wr(3'd1, 16'h0055);
    @(negedge clk);
    vblank_i = 1'b1;
    #1 chk("R9 internal edge ignored", upd_o, 0);
    @(negedge clk);
    vblank_i = 1'b0;
    @(negedge clk);
    chk("R9 size not applied by internal edge", size_o, 12'h123);
    @(negedge clk);
    ext_vblank_i = 1'b1;
    #1 chk("R9 external edge strobes", upd_o, 1);
    @(negedge clk);
    ext_vblank_i = 1'b0;
    chk("R9 size applied by external edge", size_o, 12'h055);
    wr(3'd0, 16'h0002);
    pulse(1);
    chk("R9 back to internal", sync_mode_o, 2'b00);
  endtask

  task automatic t_switch;
    wr(3'd0, 16'h0006);
    pulse(0);
    chk("R10 mode switching", sync_mode_o, 2'b01);
    chk("R10 display held off", disp_on_o, 0);
    wr(3'd1, 16'h0077);
    pulse(0);
    chk("R10 updates continue", size_o, 12'h077);
  endtask

  task automatic t_readback;
    logic [DATA_W-1:0] d;
    rd(3'd5, d); chk("R11 unmapped reads zero", d, 0);
    rd(3'd7, d); chk("R11 unmapped reads zero", d, 0);
    rd(3'd4, d); chk("R11 active size", d, 16'h0077);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage_hold();
    t_update();
    t_collision();
    t_flag();
    t_ext();
    t_switch();
    t_readback();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule